// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave device on a two-wire serial bus that holds 512 bytes of non-volatile-style storage, split into two 256-byte blocks. A system clock samples SCL and SDA. The block finds bus conditions and serial bits from those samples, and it drives SDA low through an open-drain output enable. A bus master selects the device with a select byte that carries a fixed type code, two chip-enable bits, a block bit and a direction bit. The master then loads a byte address and either writes data or reads data back.

Write data is not stored as it arrives. It is held in an eight-entry latch and committed to the array only when the master ends the transfer with STOP. During the self-timed programming period that follows, the device ignores the bus completely. A master finds out when the write is done by repeating the select byte until it is acknowledged. Two write modes are offered. In row (page) mode, up to eight bytes are accepted and the address wraps inside an aligned 8-byte row. In burst (multibyte) mode, up to four bytes are accepted and the address increments across the block. A register byte at the last address can lock the top of the upper block from a chosen 8-byte boundary while a protect input is high.

Top module: `i2c_mem_slave`

## Requirements
- R1: START (SDA falling while SCL is high) begins a new frame at any point, including a repeated START inside a transfer. STOP (SDA rising while SCL is high) returns the slave to standby. A repeated START before STOP discards any write data latched in that transfer.
- R2: The select byte is sent MSB first as bits [7:4] type code 1010, bit 3 matched against chip_sel_i[1], bit 2 matched against chip_sel_i[0], bit 1 block number, bit 0 direction (1 = read). If the type code or the chip-enable bits do not match, the slave gives no acknowledge and keeps SDA released until the next START.
- R3: The slave pulls SDA low in the 9th clock after a matching select byte, after an address byte, and after each accepted write data byte. sda_oe_o changes only while SCL is low.
- R4: With page_wr_i = 1, up to 8 data bytes are acknowledged and latched. Only address bits [2:0] advance, so the data wraps inside the 8-byte row. Further data bytes are neither acknowledged nor written.
- R5: With page_wr_i = 0, up to 4 data bytes are acknowledged and latched. Address bits [7:0] advance and the block bit is kept. A 5th or later data byte is neither acknowledged nor written.
- R6: A STOP that ends a write transfer with at least one latched byte commits the bytes to the array. The slave then stays busy for WR_CYCLES clocks and acknowledges nothing, so a select byte sent in that window gets no acknowledge. After the window the written data reads back.
- R7: A read select returns the byte at the internal 9-bit address counter, whose bit 8 is replaced by the select byte's block bit. The counter advances by one after every byte sent and after every accepted write byte.
- R8: A random read is a write select plus an address byte, followed by a repeated START and a read select. It returns the byte at the loaded address.
- R9: A read continues while the master acknowledges each byte. The counter rolls over from 1FFh to 000h. A missing acknowledge ends the read and leaves SDA released on the following clocks.
- R10: After reset every array byte reads FFh, the address counter is 000h and SDA is released.
- R11: While wr_prot_i = 1 and bit 2 of byte 1FFh is 0, committed writes to any address at or above {1, byte1FFh[7:3], 000} are dropped, though they are still acknowledged. Otherwise 1FFh is an ordinary byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | When 1, SDA is pulled low |
| chip_sel_i | input | 2 | Chip-enable bits compared with select bits [3:2] |
| page_wr_i | input | 1 | 1 = row (page) write mode, 0 = burst write mode |
| wr_prot_i | input | 1 | Enables upper-block write protection |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except to form START and STOP. They also assume that the master never issues START or STOP while the slave is driving an acknowledge or a read bit. Each SCL phase must last several system clocks so that the two synchronised lines move together. The bench's master tasks hold every SCL phase for eight clocks and move SDA only in low phases. They place START and STOP only after the slave has released the line at the end of an acknowledge or after a refused read byte. WR_CYCLES is set above the latch depth so that the commit always finishes inside the busy window.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } fsm_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_o;
      sda_d  <= sda_o;
    end
  end

  assign scl_o      = scl_sh[STAGES-1];
  assign sda_o      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // bus conditions: SDA edge while SCL stays high
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:2] cfg_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
  assign cfg_o   = mem_q[DEPTH-1][DW-1:2];
endmodule

// File: rtl/wr_commit.sv
module wr_commit #(
  parameter int AW        = 9,
  parameter int DW        = 8,
  parameter int DEPTH     = 8,
  parameter int WR_CYCLES = 2500,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH),
  localparam int TW = $clog2(WR_CYCLES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          clear_i,
  input  logic          go_i,
  input  logic          prot_en_i,
  input  logic [DW-1:2] cfg_i,
  output logic [CW-1:0] count_o,
  output logic          busy_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o
);
  logic [AW-1:0] badr_q [DEPTH];
  logic [DW-1:0] bdat_q [DEPTH];
  logic [CW-1:0] cnt_q, idx_q;
  logic [TW-1:0] tmr_q;
  logic          busy_q;
  logic          room, pending, locked;

  assign room    = cnt_q < CW'(DEPTH);
  assign pending = busy_q && (idx_q != cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      idx_q  <= '0;
      tmr_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (pending) idx_q <= idx_q + 1'b1;
      tmr_q <= tmr_q - 1'b1;
      if (tmr_q == TW'(1)) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
        idx_q  <= '0;
      end
    end else if (go_i && cnt_q != '0) begin
      busy_q <= 1'b1;
      tmr_q  <= TW'(WR_CYCLES);
      idx_q  <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (push_i && room) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!busy_q && !clear_i && push_i && room) begin
      badr_q[cnt_q[IW-1:0]] <= push_addr_i;
      bdat_q[cnt_q[IW-1:0]] <= push_data_i;
    end
  end

  assign waddr_o = badr_q[idx_q[IW-1:0]];
  assign wdata_o = bdat_q[idx_q[IW-1:0]];
  // upper block, flag bit clear, row index at or above the pointer
  assign locked  = prot_en_i && !cfg_i[2] && waddr_o[AW-1]
                   && (waddr_o[AW-2:3] >= cfg_i[DW-1:3]);
  assign we_o    = pending && !locked;
  assign busy_o  = busy_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter int WR_CYCLES   = 2500,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [1:0] chip_sel_i,
  input  logic       page_wr_i,
  input  logic       wr_prot_i
);
  localparam int AW          = 9;
  localparam int DW          = 8;
  localparam int PAGE_BYTES  = 8;
  localparam int BURST_BYTES = 4;
  localparam int CW          = $clog2(PAGE_BYTES + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic busy, mem_we, push, accept;
  logic [AW-1:0] mem_waddr, next_wa;
  logic [DW-1:0] mem_wdata, rd_data, byte_w;
  logic [DW-1:2] cfg;
  logic [CW-1:0] wr_cnt;

  fsm_e          state_q;
  logic [3:0]    bit_q;
  logic [6:0]    shreg_q;
  logic          rw_q, ack_q, oe_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] tx_q;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(bus_start), .stop_o(bus_stop)
  );

  nvm_array #(.AW(AW), .DW(DW)) u_array (
    .clk_i, .rst_ni, .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(mem_wdata),
    .raddr_i(addr_q), .rdata_o(rd_data), .cfg_o(cfg)
  );

  wr_commit #(.AW(AW), .DW(DW), .DEPTH(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)) u_commit (
    .clk_i, .rst_ni,
    .push_i(push), .push_addr_i(addr_q), .push_data_i(byte_w),
    .clear_i(bus_start), .go_i(bus_stop && state_q == ST_WDATA),
    .prot_en_i(wr_prot_i), .cfg_i(cfg), .count_o(wr_cnt), .busy_o(busy),
    .we_o(mem_we), .waddr_o(mem_waddr), .wdata_o(mem_wdata)
  );

  assign byte_w  = {shreg_q, sda_s};
  assign accept  = wr_cnt < (page_wr_i ? CW'(PAGE_BYTES) : CW'(BURST_BYTES));
  assign next_wa = page_wr_i ? {addr_q[AW-1:3], addr_q[2:0] + 3'd1}
                             : {addr_q[AW-1], addr_q[AW-2:0] + 8'd1};
  assign push    = !busy && scl_rise && state_q == ST_WDATA && bit_q == 4'd7 && accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      shreg_q <= '0;
      rw_q    <= 1'b0;
      ack_q   <= 1'b0;
      addr_q  <= '0;
      tx_q    <= '0;
      oe_q    <= 1'b0;
    end else if (busy) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else if (bus_start) begin
      state_q <= ST_DEV;
      bit_q   <= '0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else if (bus_stop) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else if (state_q != ST_IDLE) begin
      if (scl_rise) begin
        if (bit_q == 4'd8) begin
          // 9th clock: advance the frame
          bit_q <= '0;
          ack_q <= 1'b0;
          case (state_q)
            ST_DEV: begin
              if (rw_q) begin
                state_q <= ST_RDATA;
                tx_q    <= rd_data;
                addr_q  <= addr_q + 1'b1;
              end else begin
                state_q <= ST_ADDR;
              end
            end
            ST_ADDR: state_q <= ST_WDATA;
            ST_RDATA: begin
              if (!sda_s) begin
                tx_q   <= rd_data;
                addr_q <= addr_q + 1'b1;
              end else begin
                state_q <= ST_IDLE;
              end
            end
            default: ;
          endcase
        end else begin
          shreg_q <= byte_w[6:0];
          bit_q   <= bit_q + 4'd1;
          if (bit_q == 4'd7) begin
            case (state_q)
              ST_DEV: begin
                if (byte_w[7:4] == DEV_TYPE && byte_w[3:2] == chip_sel_i) begin
                  ack_q      <= 1'b1;
                  rw_q       <= byte_w[0];
                  addr_q[AW-1] <= byte_w[1];
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              ST_ADDR: begin
                ack_q        <= 1'b1;
                addr_q[7:0]  <= byte_w;
              end
              ST_WDATA: begin
                if (accept) begin
                  ack_q  <= 1'b1;
                  addr_q <= next_wa;
                end
              end
              default: ;
            endcase
          end
        end
      end else if (scl_fall) begin
        if (bit_q == 4'd8)            oe_q <= ack_q;
        else if (state_q == ST_RDATA) oe_q <= ~tx_q[~bit_q[2:0]];
        else                          oe_q <= 1'b0;
      end
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk
  import i2c_mem_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          busy,
  input logic          mem_we,
  input fsm_e          state,
  input logic [CW-1:0] wr_cnt
);
  // R6
  busy_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !sda_oe);

  // R3
  oe_low_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  // R6
  commit_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> busy);

  // R2
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> !sda_oe);

  // R4
  latch_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt <= CW'(DEPTH));
endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.DEPTH(8)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .sda_oe(sda_oe_o),
  .busy(busy), .mem_we(mem_we), .state(state_q), .wr_cnt(wr_cnt)
);

// File: tb/tb_i2c_mem_slave.sv
module tb_i2c_mem_slave;
  localparam int WRC = 600;
  localparam int Q   = 8;
  localparam logic [1:0] CS = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_low = 1'b0, page_wr = 1'b1, wr_prot = 1'b0;
  logic sda_oe, sda_bus;
  int total = 0, bad = 0;
  logic done = 1'b0;

  logic [7:0] model_q [512];
  logic [7:0] wbuf [16];
  logic       ackv [16];
  logic [7:0] rbuf [16];

  always #2 clk = ~clk;
  assign sda_bus = !(m_low || sda_oe);

  i2c_mem_slave #(.WR_CYCLES(WRC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .chip_sel_i(CS), .page_wr_i(page_wr), .wr_prot_i(wr_prot)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sel(input logic blk, input logic rd);
    return {4'b1010, CS, blk, rd};
  endfunction

  task automatic bus_start();
    m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_low = 1'b1; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; tick(Q); scl = 1'b1; tick(Q); m_low = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = !b[i]; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0;
    end
    m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q/2); ack = !sda_bus; tick(Q/2); scl = 1'b0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q/2); b[i] = sda_bus; tick(Q/2); scl = 1'b0;
    end
    m_low = mack; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q/2); m_low = 1'b0;
  endtask

  task automatic do_write(input logic [8:0] a, input int n);
    logic k;
    bus_start();
    send_byte(sel(a[8], 1'b0), k); check("R3 write select ack", k, 1);
    send_byte(a[7:0], k);          check("R3 address ack", k, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], k);
      ackv[i] = k;
    end
    bus_stop();
  endtask

  task automatic model_write(input logic [8:0] a, input int n, input logic pg);
    int lim;
    int m;
    logic [8:0] ad;
    logic [8:0] la [8];
    logic [7:0] ld [8];
    lim = pg ? 8 : 4;
    m = 0;
    ad = a;
    for (int i = 0; i < n; i++) begin
      check(pg ? "R4 row data ack" : "R5 burst data ack", 32'(ackv[i]), 32'(i < lim));
      if (i < lim) begin
        la[m] = ad; ld[m] = wbuf[i]; m++;
        ad = pg ? {ad[8:3], ad[2:0] + 3'd1} : {ad[8], ad[7:0] + 8'd1};
      end
    end
    for (int j = 0; j < m; j++)
      if (!(wr_prot && !model_q[511][2] && la[j][8] && la[j][7:3] >= model_q[511][7:3]))
        model_q[la[j]] = ld[j];
  endtask

  task automatic write_and_wait(input logic [8:0] a, input int n);
    do_write(a, n);
    model_write(a, n, page_wr);
    tick(WRC + 20);
  endtask

  task automatic read_rand(input logic [8:0] a, input int n);
    logic k;
    bus_start();
    send_byte(sel(a[8], 1'b0), k);
    send_byte(a[7:0], k);
    bus_start();
    send_byte(sel(a[8], 1'b1), k); check("R8 read select ack", k, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bus_stop();
  endtask

  task automatic read_cur(input logic blk, output logic [7:0] b);
    logic k;
    bus_start();
    send_byte(sel(blk, 1'b1), k); check("R7 current select ack", k, 1);
    recv_byte(1'b0, b);
    bus_stop();
  endtask

  task automatic byte_wr(input logic [8:0] a, input logic [7:0] d);
    wbuf[0] = d;
    write_and_wait(a, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic k;
    logic [7:0] b;
    void'($urandom(32'd4242));
    for (int i = 0; i < 512; i++) model_q[i] = 8'hFF;
    tick(5); rst_n = 1'b1; tick(5);

    // reset state
    check("R10 sda released", 32'(sda_oe), 0);
    read_cur(1'b0, b); check("R10 erased byte", b, 8'hFF);
    read_cur(1'b0, b); check("R10 erased byte next", b, 8'hFF);

    // select mismatch
    bus_start();
    send_byte({4'b1010, ~CS, 2'b00}, k); check("R2 chip-enable mismatch", k, 0);
    send_byte(8'h00, k);                 check("R2 released after mismatch", k, 0);
    bus_start();
    send_byte({4'b1011, CS, 2'b00}, k);  check("R2 type mismatch", k, 0);
    bus_start();
    send_byte(sel(1'b0, 1'b0), k);       check("R1 restart recovers", k, 1);
    bus_stop();

    // byte writes, busy polling
    wbuf[0] = 8'h5E;
    do_write(9'h000, 1);
    model_write(9'h000, 1, page_wr);
    bus_start();
    send_byte(sel(1'b0, 1'b0), k); check("R6 busy no ack", k, 0);
    bus_stop();
    tick(WRC + 20);
    bus_start();
    send_byte(sel(1'b0, 1'b0), k); check("R6 ready ack", k, 1);
    bus_stop();
    byte_wr(9'h001, 8'h3C);
    byte_wr(9'h102, 8'hC3);
    byte_wr(9'h1FF, 8'h77);
    byte_wr(9'h020, 8'hAA);
    read_rand(9'h000, 1); check("R8 random read", rbuf[0], model_q[0]);

    // repeated START discards latched data
    bus_start();
    send_byte(sel(1'b0, 1'b0), k);
    send_byte(8'h20, k);
    send_byte(8'h5A, k); check("R3 data ack", k, 1);
    bus_start();
    send_byte(sel(1'b0, 1'b1), k);
    recv_byte(1'b0, b); check("R7 counter after data", b, model_q[9'h021]);
    bus_stop();
    bus_start();
    send_byte(sel(1'b0, 1'b0), k); check("R1 no commit after restart", k, 1);
    bus_stop();
    read_rand(9'h020, 1); check("R1 discarded data", rbuf[0], 8'hAA);

    // sequential read rollover, current address, block bit
    read_rand(9'h1FF, 2);
    check("R9 last byte", rbuf[0], model_q[9'h1FF]);
    check("R9 rollover", rbuf[1], model_q[9'h000]);
    read_cur(1'b0, b); check("R7 current read", b, model_q[9'h001]);
    read_cur(1'b1, b); check("R7 block bit", b, model_q[9'h102]);

    // read NACK ends transfer
    read_rand(9'h000, 1);
    tick(Q);
    for (int i = 0; i < 9; i++) begin
      tick(Q); scl = 1'b1; tick(Q/2);
      check("R9 standby after nack", 32'(sda_oe), 0);
      tick(Q/2); scl = 1'b0;
    end
    bus_stop();

    // row write wraps, 9th byte refused
    page_wr = 1'b1;
    for (int i = 0; i < 9; i++) wbuf[i] = 8'h10 + 8'(i);
    write_and_wait(9'h00D, 9);
    read_rand(9'h008, 8);
    for (int i = 0; i < 8; i++) check("R4 row wrap", rbuf[i], model_q[9'h008 + 9'(i)]);

    // burst write crosses a row, 5th byte refused
    page_wr = 1'b0;
    for (int i = 0; i < 5; i++) wbuf[i] = 8'hB0 + 8'(i);
    write_and_wait(9'h03E, 5);
    read_rand(9'h03E, 5);
    for (int i = 0; i < 5; i++) check("R5 burst span", rbuf[i], model_q[9'h03E + 9'(i)]);

    // random writes
    for (int it = 0; it < 12; it++) begin
      logic [8:0] a;
      logic [8:0] base;
      int n;
      a = 9'($urandom % 511);
      n = 1 + int'($urandom % 10);
      page_wr = 1'($urandom % 2);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      write_and_wait(a, n);
      base = page_wr ? {a[8:3], 3'b000} : a;
      read_rand(base, 8);
      for (int i = 0; i < 8; i++)
        check(page_wr ? "R4 random row" : "R5 random burst", rbuf[i], model_q[base + 9'(i)]);
    end

    // write protection
    page_wr = 1'b1;
    wr_prot = 1'b0;
    byte_wr(9'h1FF, 8'hF0);
    byte_wr(9'h1F4, 8'h44);
    wr_prot = 1'b1;
    byte_wr(9'h1F4, 8'h11);
    read_rand(9'h1F4, 1); check("R11 protected byte kept", rbuf[0], 8'h44);
    byte_wr(9'h1E8, 8'h22);
    read_rand(9'h1E8, 1); check("R11 below boundary written", rbuf[0], 8'h22);
    byte_wr(9'h1FF, 8'h00);
    read_rand(9'h1FF, 1); check("R11 pointer protected", rbuf[0], 8'hF0);
    wr_prot = 1'b0;
    byte_wr(9'h1FF, 8'hF4);
    wr_prot = 1'b1;
    byte_wr(9'h1F4, 8'h33);
    read_rand(9'h1F4, 1); check("R11 flag set unlocks", rbuf[0], 8'h33);
    wr_prot = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule